// File: doc/BRIEF.md
# Per-Register Physical Bank State Table

This block manages the physical registers of one logical register. It holds them in a circular table of `DEPTH` entries. Each entry stores a state identifier, a valid flag and a ready flag. Three one-hot pointers move around the table:

- the rename pointer marks the newest mapping;
- the commit pointer marks the oldest entry whose state has not yet been committed;
- the release pointer marks the oldest entry still held.

Entries are taken and given back strictly in FIFO order, so no free list or alias table is needed.

Each cycle the block can accept up to two renames of its logical register. It collects writeback strobes, per-entry "all dependents consumed" and "state finished" indications, and the globally oldest committed identifier. It also accepts a broadcast recovery identifier that rolls the bank back. It offers the identifier at its commit pointer to a global minimum tree, and masks that offer when the value has no bearing on commit. State identifiers are compared as plain unsigned numbers. The global counter keeps them ordered. `DEPTH` must be a power of two.

Top module: `bank_state_table`

## Requirements
- R1: After reset, map_idx is 0, com_id is 0 and com_vld is 0. Entry 0 is the only valid entry; it holds identifier 0, it is ready, and all three pointers point at it.
- R2: When ren_cnt is 1 or 2 and stall is low, the next ren_cnt entries after the rename pointer are filled. The older request writes ren_id_a and the younger writes ren_id_b. map_idx then advances by ren_cnt, modulo DEPTH, on the next cycle.
- R3: ren_cnt equal to 3 raises stall in the same cycle, and no rename is accepted.
- R4: stall is raised whenever the valid entries plus ren_cnt would exceed DEPTH. Nothing is then accepted, and there is no partial acceptance. With all DEPTH entries valid (rename and release pointers adjacent), any nonzero ren_cnt stalls.
- R5: The commit pointer advances by one entry per cycle when its entry is ready and st_done for it is 1, unless it already equals the rename pointer. com_id shows the identifier at the commit pointer.
- R6: The release pointer frees its entry and advances by one when all of the following hold: the entry is ready, cons_done for it is 1, its identifier is below lcs_id, and the release pointer differs from the commit pointer. The freed room is usable by renames from the next cycle.
- R7: In a cycle with rec_valid high, every entry younger than the oldest whose identifier exceeds rec_id is freed. The rename pointer moves to the youngest survivor, and the commit pointer is pulled back to it if it lay beyond. stall is high, and no rename, writeback, commit or release happens in that cycle.
- R8: At least one entry, the latest rename, is always valid, and it is never released.
- R9: com_vld is 0 exactly when the commit and rename pointers coincide and that entry is ready.
- R10: A writeback strobe for an entry that is not valid is ignored. A freshly renamed entry starts not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_cnt | input | 2 | Number of renames of this register requested this cycle (0..3) |
| ren_id_a | input | IDW | Identifier for the older rename |
| ren_id_b | input | IDW | Identifier for the younger rename |
| wb_rdy | input | DEPTH | Per-entry writeback strobes |
| cons_done | input | DEPTH | Per-entry: all dependents have read the value |
| st_done | input | DEPTH | Per-entry: all non-writing instructions of the state have issued |
| lcs_id | input | IDW | Oldest committable state identifier |
| rec_valid | input | 1 | Recovery broadcast strobe |
| rec_id | input | IDW | Recovery state identifier |
| map_idx | output | log2(DEPTH) | Entry index of the current mapping |
| stall | output | 1 | Rename cannot be accepted this cycle |
| com_id | output | IDW | Identifier at the commit pointer |
| com_vld | output | 1 | com_id takes part in the global minimum |

## Verification
The bench goes after the following corner cases:

- **Full bank.** An off-by-one in the occupancy count would either overwrite the oldest live entry or stall one entry early.
- **Double rename across the wrap point.** A wrong rotation would leave the mapping one slot off.
- **Recovery that keeps only the oldest entry, and recovery that pulls the commit pointer back.** A design that trusted the identifiers alone would empty the bank, or leave the commit pointer past the mapping.
- **Release racing the commit pointer, and writeback strobes aimed at free entries.** A design that ignored either would free an uncommitted register, or mark a fresh rename ready before its result exists.

// File: rtl/bank_state_table.sv
module bank_state_table #(
  parameter int DEPTH = 8,
  parameter int IDW   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               ren_cnt,
  input  logic [IDW-1:0]           ren_id_a,
  input  logic [IDW-1:0]           ren_id_b,
  input  logic [DEPTH-1:0]         wb_rdy,
  input  logic [DEPTH-1:0]         cons_done,
  input  logic [DEPTH-1:0]         st_done,
  input  logic [IDW-1:0]           lcs_id,
  input  logic                     rec_valid,
  input  logic [IDW-1:0]           rec_id,
  output logic [$clog2(DEPTH)-1:0] map_idx,
  output logic                     stall,
  output logic [IDW-1:0]           com_id,
  output logic                     com_vld
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DEPTH-1:0] renp, comp, relp, vld, rdy;
  logic [IDW-1:0]   ids [DEPTH];

  function automatic logic [AW-1:0] enc(input logic [DEPTH-1:0] v);
    logic [AW-1:0] r;
    r = '0;
    for (int i = 0; i < DEPTH; i++)
      if (v[i]) r = r | AW'(i);
    return r;
  endfunction

  function automatic logic [DEPTH-1:0] rot(input logic [DEPTH-1:0] v, input logic [1:0] n);
    logic [DEPTH-1:0] r;
    r = v;
    for (int s = 0; s < 2; s++)
      if (s < int'(n)) r = {r[DEPTH-2:0], r[DEPTH-1]};
    return r;
  endfunction

  logic [AW-1:0] ren_i, com_i, rel_i, ren_off, com_off, keep_off;
  logic [CW-1:0] used, room, surv;
  logic [1:0]    n_acc;
  logic          cadv, radv;

  assign ren_i   = enc(renp);
  assign com_i   = enc(comp);
  assign rel_i   = enc(relp);
  assign ren_off = ren_i - rel_i;
  assign com_off = com_i - rel_i;
  assign used    = {1'b0, ren_off} + CW'(1);
  assign room    = CW'(DEPTH) - used;

  assign stall   = rec_valid | (ren_cnt == 2'd3) | (CW'(ren_cnt) > room);
  assign n_acc   = stall ? 2'd0 : ren_cnt;

  assign cadv    = (comp != renp) & rdy[com_i] & st_done[com_i];
  assign radv    = (relp != comp) & rdy[rel_i] & cons_done[rel_i] & (ids[rel_i] < lcs_id);

  always_comb begin
    logic alive;
    surv  = CW'(1);
    alive = 1'b1;
    for (int k = 1; k < DEPTH; k++) begin
      if (alive && CW'(k) <= {1'b0, ren_off} && ids[rel_i + AW'(k)] <= rec_id)
        surv = surv + CW'(1);
      else
        alive = 1'b0;
    end
  end
  assign keep_off = AW'(surv - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= DEPTH'(1);
      rdy  <= DEPTH'(1);
      renp <= DEPTH'(1);
      comp <= DEPTH'(1);
      relp <= DEPTH'(1);
      for (int i = 0; i < DEPTH; i++) ids[i] <= '0;
    end else if (rec_valid) begin
      for (int k = 1; k < DEPTH; k++)
        if (CW'(k) >= surv) begin
          vld[rel_i + AW'(k)] <= 1'b0;
          rdy[rel_i + AW'(k)] <= 1'b0;
        end
      renp <= DEPTH'(1) << (rel_i + keep_off);
      if (com_off > keep_off) comp <= DEPTH'(1) << (rel_i + keep_off);
    end else begin
      rdy <= rdy | (wb_rdy & vld);
      if (radv) begin
        vld[rel_i] <= 1'b0;
        rdy[rel_i] <= 1'b0;
        relp       <= rot(relp, 2'd1);
      end
      if (cadv) comp <= rot(comp, 2'd1);
      if (n_acc != 2'd0) begin
        vld[ren_i + AW'(1)] <= 1'b1;
        rdy[ren_i + AW'(1)] <= 1'b0;
        ids[ren_i + AW'(1)] <= ren_id_a;
      end
      if (n_acc == 2'd2) begin
        vld[ren_i + AW'(2)] <= 1'b1;
        rdy[ren_i + AW'(2)] <= 1'b0;
        ids[ren_i + AW'(2)] <= ren_id_b;
      end
      renp <= rot(renp, n_acc);
    end
  end

  assign map_idx = ren_i;
  assign com_id  = ids[com_i];
  assign com_vld = !((comp == renp) & rdy[com_i]);
endmodule

// File: rtl/bank_state_table_chk.sv
module bank_state_table_chk #(
  parameter int DEPTH = 8,
  parameter int IDW   = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [DEPTH-1:0]         renp,
  input logic [DEPTH-1:0]         comp,
  input logic [DEPTH-1:0]         relp,
  input logic [DEPTH-1:0]         vld,
  input logic [DEPTH-1:0]         rdy,
  input logic [1:0]               ren_cnt,
  input logic                     rec_valid,
  input logic                     stall,
  input logic                     com_vld,
  input logic [$clog2(DEPTH)-1:0] map_idx
);
  localparam int AW = $clog2(DEPTH);

  function automatic logic [AW-1:0] idx(input logic [DEPTH-1:0] v);
    logic [AW-1:0] r;
    r = '0;
    for (int i = 0; i < DEPTH; i++)
      if (v[i]) r = r | AW'(i);
    return r;
  endfunction

  logic [AW-1:0] c_ren_off, c_com_off;
  assign c_ren_off = idx(renp) - idx(relp);
  assign c_com_off = idx(comp) - idx(relp);

  AST_PTR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(renp) == 1 && $countones(comp) == 1 && $countones(relp) == 1); // R2
  AST_MAP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    vld[map_idx]); // R8
  AST_PTR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    c_com_off <= c_ren_off); // R5
  AST_VALID_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld) == int'(c_ren_off) + 1); // R6
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(vld) == DEPTH && ren_cnt != 2'd0) |-> stall); // R4
  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !rec_valid) |=> map_idx == $past(map_idx)); // R3
  AST_REN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && ren_cnt != 2'd0) |=> map_idx == AW'($past(map_idx) + AW'($past(ren_cnt)))); // R2
  AST_EXCLUDE: assert property (@(posedge clk) disable iff (!rst_n)
    (renp == comp && rdy[map_idx]) |-> !com_vld); // R9
endmodule

bind bank_state_table bank_state_table_chk #(.DEPTH(DEPTH), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .renp(renp), .comp(comp), .relp(relp),
  .vld(vld), .rdy(rdy), .ren_cnt(ren_cnt), .rec_valid(rec_valid),
  .stall(stall), .com_vld(com_vld), .map_idx(map_idx)
);

// File: tb/bank_state_table_test.sv
`timescale 1ns/1ps
module bank_state_table_test;
  localparam int D = 8;
  localparam int W = 8;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic [1:0]   ren_cnt = '0;
  logic [W-1:0] ren_id_a = '0, ren_id_b = '0, lcs_id = '0, rec_id = '0;
  logic [D-1:0] wb_rdy = '0, cons_done = '0, st_done = '0;
  logic         rec_valid = 1'b0;
  logic [2:0]   map_idx;
  logic         stall, com_vld;
  logic [W-1:0] com_id;

  bank_state_table #(.DEPTH(D), .IDW(W)) uut (
    .clk(clk), .rst_n(rst_n), .ren_cnt(ren_cnt), .ren_id_a(ren_id_a), .ren_id_b(ren_id_b),
    .wb_rdy(wb_rdy), .cons_done(cons_done), .st_done(st_done), .lcs_id(lcs_id),
    .rec_valid(rec_valid), .rec_id(rec_id), .map_idx(map_idx), .stall(stall),
    .com_id(com_id), .com_vld(com_vld)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int mids[D];
  bit mrdy[D];
  int mrel, mcnt, mcoff, sc;
  bit [31:0] seed = 32'h1234_5678;

  function automatic int unsigned nxt();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ren_cnt = '0; wb_rdy = '0; cons_done = '0; st_done = '0;
    rec_valid = 1'b0; lcs_id = '0; rec_id = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int i = 0; i < D; i++) begin mids[i] = 0; mrdy[i] = 1'b0; end
    mrdy[0] = 1'b1; mrel = 0; mcnt = 1; mcoff = 0; sc = 0;
    #1;
    chk("R1 map_idx", map_idx, 0);
    chk("R1 com_id", com_id, 0);
    chk("R1 com_vld", com_vld, 0);
    chk("R1 stall", stall, 0);
  endtask

  task automatic cyc(input int rc, input bit [D-1:0] wb, input bit [D-1:0] cd,
                     input bit [D-1:0] sd, input int lcs, input bit rv, input int rid);
    int n, ci, ri, surv;
    bit cadv, radv, est, alive;
    ren_cnt = 2'(rc); ren_id_a = W'(sc + 1); ren_id_b = W'(sc + 2);
    wb_rdy = wb; cons_done = cd; st_done = sd; lcs_id = W'(lcs);
    rec_valid = rv; rec_id = W'(rid);
    #1;
    est = rv || rc == 3 || rc > D - mcnt;
    chk(rc == 3 ? "R3 stall" : (rv ? "R7 stall" : "R4 R6 stall"), stall, est);
    ci = (mrel + mcoff) % D;
    if (rv) begin
      surv = 1; alive = 1'b1;
      for (int k = 1; k < mcnt; k++)
        if (alive && mids[(mrel + k) % D] <= rid) surv++; else alive = 1'b0;
      mcnt = surv;
      if (mcoff > surv - 1) mcoff = surv - 1;
      sc = rid;
    end else begin
      n = est ? 0 : rc;
      cadv = (mcoff != mcnt - 1) && mrdy[ci] && sd[ci];
      radv = (mcoff != 0) && mrdy[mrel] && cd[mrel] && (mids[mrel] < lcs);
      for (int i = 0; i < D; i++)
        if (((i - mrel + D) % D) < mcnt && wb[i]) mrdy[i] = 1'b1;
      ri = (mrel + mcnt - 1) % D;
      for (int j = 0; j < n; j++) begin
        mids[(ri + 1 + j) % D] = sc + 1 + j;
        mrdy[(ri + 1 + j) % D] = 1'b0;
      end
      sc = sc + n;
      mrel = (mrel + int'(radv)) % D;
      mcnt = mcnt + n - int'(radv);
      mcoff = mcoff + int'(cadv) - int'(radv);
    end
    @(posedge clk);
    #1;
    ci = (mrel + mcoff) % D;
    chk(rv ? "R7 R8 map_idx" : "R2 R8 map_idx", map_idx, (mrel + mcnt - 1) % D);
    chk("R5 com_id", com_id, mids[ci]);
    chk("R9 R10 com_vld", com_vld, !(mcoff == mcnt - 1 && mrdy[ci]));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // fill the bank with double renames, then hit the full and third-rename stalls
    cyc(2, '0, '0, '0, 0, 0, 0);
    cyc(2, '0, '0, '0, 0, 0, 0);
    cyc(2, '0, '0, '0, 0, 0, 0);
    cyc(1, '0, '0, '0, 0, 0, 0);
    cyc(1, '0, '0, '0, 0, 0, 0);
    cyc(3, '0, '0, '0, 0, 0, 0);
    // writeback then commit walk, then releases
    cyc(0, 8'hFF, '0, '0, 0, 0, 0);
    cyc(0, '0, '0, 8'hFF, 0, 0, 0);
    cyc(0, '0, '0, 8'hFF, 0, 0, 0);
    cyc(0, '0, 8'hFF, 8'hFF, 255, 0, 0);
    cyc(2, '0, 8'hFF, 8'hFF, 255, 0, 0);
    cyc(0, '0, 8'hFF, 8'hFF, 255, 0, 0);
    // recovery that keeps only the oldest entry
    cyc(0, '0, '0, '0, 0, 1, mids[mrel]);
    cyc(2, 8'hFF, '0, '0, 0, 0, 0);
    for (int ep = 0; ep < 40; ep++) begin
      do_reset();
      for (int t = 0; t < 110; t++) begin
        int unsigned r;
        int rc, lo, lcs, rid;
        bit rv;
        bit [D-1:0] wb, cd, sd;
        r  = nxt();
        rc = (r % 16 == 0) ? 3 : int'((r >> 4) % 3);
        wb = D'(nxt()); cd = D'(nxt()); sd = D'(nxt());
        if (ep % 4 == 1) wb = wb & D'(nxt());
        if (ep % 4 == 2) begin cd = cd | D'(nxt()); sd = sd | D'(nxt()); end
        if (ep % 4 == 3) sd = sd & D'(nxt());
        lo  = mids[mrel];
        lcs = lo + int'(nxt() % (sc - lo + 2));
        if (lcs > 255) lcs = 255;
        rv  = (nxt() % 18 == 0);
        rid = lo + int'(nxt() % (sc - lo + 1));
        cyc(rc, wb, cd, sd, lcs, rv, rid);
      end
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule